// File: doc/BRIEF.md
# Four-Way Replacement Victim Selector

This block decides which way of a 4-way, 64-set cache gets the new line when a lookup misses. A mode input picks the policy for each request. With the mode high, each set has its own 2-bit rotating pointer. The victim is the pointer's present value, and the pointer then moves on by one. With the mode low, one 32-bit scrambler state is shared by all sets. On each pick it is stepped with a cheap multiply-and-XOR rule, and two of its bits give the way.

The victim output is combinational from the current state and the request inputs. The cache controller can therefore write the new tag into the chosen way in the same cycle that it raises the miss strobe. State only moves on the clock edge that ends a strobed cycle.

Top module: `victim_sel`

## Requirements
- R1: `way_o` shows the victim for the presented `set_i` and `rr_mode_i` in the same cycle as the inputs, before the clock edge that consumes the miss.
- R2: In rotating mode (`rr_mode_i`=1), `way_o` equals the addressed set's pointer, and a strobed miss adds one to that pointer.
- R3: A pointer at way 3 wraps to way 0 on its next strobed miss.
- R4: Each of the 64 sets has its own pointer, including set 0 and set 63. A miss on one set leaves every other pointer unchanged.
- R5: After reset, every pointer reads way 0.
- R6: After reset, the scrambler state is decimal 44203, so the first random pick is computed from that value.
- R7: In random mode (`rr_mode_i`=0), a strobed miss replaces the state s with s ^ (s*17) ^ (s*7), with both products taken from the old s and kept to 32 bits. `way_o` is bits [18:17] of that new value.
- R8: Random-mode misses leave all rotating pointers unchanged.
- R9: Rotating-mode misses leave the scrambler state unchanged.
- R10: With `miss_i` low, neither the pointers nor the scrambler state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_i | input | 1 | Miss strobe; the selected state steps at the end of this cycle |
| set_i | input | 6 | Set index of the missing access |
| rr_mode_i | input | 1 | 1 = per-set rotating pointer, 0 = shared scrambler |
| way_o | output | 2 | Way to replace |

## Verification
The victim is due in the very cycle its inputs are presented. The bench therefore drives inputs on the falling edge and compares `way_o` one nanosecond later, before the rising edge that updates state. The effect of a miss on state is due after that rising edge. It is checked by the next presented request, either another pick or a strobe-free look at the same set. The bench's reference model advances only on the requests it strobes, so each expected value follows the cycle in which the design's own registers change.

// File: rtl/victim_pkg.sv
// Package: shared geometry and policy constants of the victim selector.
// Assumes a power-of-two set and way count.
package victim_pkg;
    localparam int unsigned NUM_SETS   = 64;
    localparam int unsigned NUM_WAYS   = 4;
    localparam int unsigned SET_W      = $clog2(NUM_SETS);
    localparam int unsigned WAY_W      = $clog2(NUM_WAYS);
    localparam int unsigned SCR_W      = 32;
    localparam int unsigned SCR_PICK_LO = 17;
    localparam logic [SCR_W-1:0] SCR_SEED = 32'd44203;

    typedef enum logic {
        POL_RANDOM = 1'b0,
        POL_ROTATE = 1'b1
    } policy_e;
endpackage

// File: rtl/victim_rr_bank.sv
// Module: bank of per-set rotating pointers.
// The read is combinational on set_i. A step advances only the addressed
// pointer, modulo the way count. Assumes synchronous active-low reset.
module victim_rr_bank #(
    parameter int unsigned SETS  = 64,
    parameter int unsigned WAYW  = 2,
    localparam int unsigned SETW = $clog2(SETS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_i,
    input  logic [SETW-1:0] set_i,
    output logic [WAYW-1:0] way_o
);
    logic [SETS-1:0][WAYW-1:0] ptr_flat;

    for (genvar g = 0; g < SETS; g++) begin : g_set
        logic [WAYW-1:0] ptr_q;
        // Purpose: clear on reset, advance when this set is stepped.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ptr_q <= '0;
            else if (step_i && (set_i == SETW'(g)))
                ptr_q <= ptr_q + 1'b1;
        end
        assign ptr_flat[g] = ptr_q;
    end

    // Purpose: present the addressed set's pointer.
    assign way_o = ptr_flat[set_i];

    // A step moves the addressed pointer on by one (wrapping).
    assert_rr_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> ptr_flat[$past(set_i)] == WAYW'($past(way_o) + 1'b1));

    // No step: every pointer holds.
    assert_rr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(ptr_flat));
endmodule

// File: rtl/victim_prng.sv
// Module: shared scrambler for random victim choice.
// Next state = s ^ 17s ^ 7s, built from shift-add terms. The pick is taken
// from the next state, so it is valid in the request cycle.
module victim_prng #(
    parameter int unsigned W       = 32,
    parameter int unsigned PICK_LO = 17,
    parameter int unsigned PICK_W  = 2,
    parameter logic [W-1:0] SEED   = 32'd44203
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    output logic [PICK_W-1:0] pick_o
);
    logic [W-1:0] state_q;
    logic [W-1:0] times17;
    logic [W-1:0] times7;
    logic [W-1:0] state_nx;

    // Purpose: form the products by shift-add and mix them into the next state.
    always_comb begin
        times17  = (state_q << 4) + state_q;
        times7   = (state_q << 3) - state_q;
        state_nx = state_q ^ times17 ^ times7;
    end

    // Purpose: seed on reset, step only on request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SEED;
        else if (step_i)
            state_q <= state_nx;
    end

    // Purpose: extract the victim bits from the stepped value.
    assign pick_o = state_nx[PICK_LO +: PICK_W];

    // Step rule checked against plain multiplication.
    assert_prng_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> state_q == ($past(state_q) ^ W'($past(state_q) * 17)
                                              ^ W'($past(state_q) * 7)));

    // Without a step the state holds.
    assert_prng_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(state_q));
endmodule

// File: rtl/victim_sel.sv
// Module: top of the victim selector. It routes the miss strobe to the
// policy chosen by rr_mode_i and muxes that policy's victim onto way_o.
// Assumes rr_mode_i and set_i are stable while miss_i is high.
module victim_sel
    import victim_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_i,
    input  logic [SET_W-1:0] set_i,
    input  logic             rr_mode_i,
    output logic [WAY_W-1:0] way_o
);
    logic             rr_step;
    logic             rnd_step;
    logic [WAY_W-1:0] rr_way;
    logic [WAY_W-1:0] rnd_way;

    // Purpose: steer the strobe to exactly one policy.
    assign rr_step  = miss_i && (policy_e'(rr_mode_i) == POL_ROTATE);
    assign rnd_step = miss_i && (policy_e'(rr_mode_i) == POL_RANDOM);

    victim_rr_bank #(.SETS(NUM_SETS), .WAYW(WAY_W)) u_rr (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (rr_step),
        .set_i  (set_i),
        .way_o  (rr_way)
    );

    victim_prng #(.W(SCR_W), .PICK_LO(SCR_PICK_LO), .PICK_W(WAY_W),
                  .SEED(SCR_SEED)) u_rnd (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (rnd_step),
        .pick_o (rnd_way)
    );

    // Purpose: present the active policy's victim.
    assign way_o = rr_mode_i ? rr_way : rnd_way;

    // Both policies never step together.
    assert_one_policy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rr_step && rnd_step));
endmodule

// File: tb/victim_sel_test.sv
module victim_sel_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       miss_i = 1'b0;
    logic [5:0] set_i = '0;
    logic       rr_mode_i = 1'b0;
    logic [1:0] way_o;

    int unsigned vecs = 0;
    int unsigned errs = 0;
    logic [1:0]  ptr_m [64];
    logic [31:0] s_m;

    always #2 clk = ~clk;

    victim_sel uut (.clk(clk), .rst_n(rst_n), .miss_i(miss_i), .set_i(set_i),
                    .rr_mode_i(rr_mode_i), .way_o(way_o));

    function automatic logic [31:0] scr_next(input logic [31:0] s);
        logic [31:0] a = s * 32'd17;
        logic [31:0] b = s * 32'd7;
        return s ^ a ^ b;
    endfunction

    task automatic check(input logic [1:0] exp, input string req);
        vecs++;
        if (way_o !== exp) begin
            errs++;
            $display("FAIL %s: way_o=%0d expected %0d", req, way_o, exp);
        end
    endtask

    // One strobed miss; the victim is compared before the consuming edge.
    task automatic pick(input logic mode, input logic [5:0] s, input string req);
        logic [1:0] exp;
        @(negedge clk);
        rr_mode_i = mode; set_i = s; miss_i = 1'b1;
        if (mode) begin
            exp = ptr_m[s];
            ptr_m[s] = ptr_m[s] + 2'd1;
        end else begin
            s_m = scr_next(s_m);
            exp = s_m[18:17];
        end
        #1 check(exp, req);
        @(negedge clk);
        miss_i = 1'b0;
    endtask

    // Look without a strobe: shows state, changes nothing.
    task automatic peek(input logic mode, input logic [5:0] s, input string req);
        @(negedge clk);
        miss_i = 1'b0; rr_mode_i = mode; set_i = s;
        #1 check(mode ? ptr_m[s] : scr_next(s_m)[18:17], req);
    endtask

    task automatic t_reset();
        peek(1'b1, 6'd0,  "R5 pointer set0 after reset");
        peek(1'b1, 6'd63, "R5 pointer set63 after reset");
        peek(1'b0, 6'd0,  "R6 first random pick from seed");
    endtask

    task automatic t_rotate_wrap();
        for (int i = 0; i < 6; i++) pick(1'b1, 6'd5, "R2/R3/R1 rotate set5");
        peek(1'b1, 6'd5, "R3 wrapped pointer set5");
    endtask

    task automatic t_independent();
        peek(1'b1, 6'd4, "R4 neighbour set4 untouched");
        pick(1'b1, 6'd63, "R4 set63 own pointer");
        pick(1'b1, 6'd0,  "R4 set0 own pointer");
        peek(1'b1, 6'd63, "R4 set63 after set0 miss");
        peek(1'b1, 6'd5,  "R4 set5 kept");
    endtask

    task automatic t_random();
        for (int i = 0; i < 12; i++) pick(1'b0, 6'(i * 5), "R7 random pick");
        peek(1'b1, 6'd5, "R8 pointer set5 after random misses");
        peek(1'b1, 6'd0, "R8 pointer set0 after random misses");
    endtask

    task automatic t_rotate_freezes_random();
        for (int i = 0; i < 5; i++) pick(1'b1, 6'd20, "R2 rotate set20");
        pick(1'b0, 6'd1, "R9 random sequence continues");
        pick(1'b0, 6'd2, "R9 random sequence continues");
    endtask

    task automatic t_hold();
        for (int i = 0; i < 4; i++) peek(1'b0, 6'd7, "R10 random state held");
        peek(1'b1, 6'd20, "R10 pointer held");
        pick(1'b0, 6'd9, "R10 next random after idle");
    endtask

    initial begin
        for (int i = 0; i < 64; i++) ptr_m[i] = 2'd0;
        s_m = 32'd44203;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rotate_wrap();
        t_independent();
        t_random();
        t_rotate_freezes_random();
        t_hold();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        #400000;
        errs++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule